// File: doc/BRIEF.md
# Buffer Memory Byte Transfer Master

This block carries bytes between an internal byte stream and an external byte-wide buffer memory. The memory asks for service by raising a request line. The block answers by pulling an open-drain chip select low. It then issues a train of write or read strobes, and the falls of successive strobes are spaced by a programmable transfer period counted in clock cycles. Each byte on the memory bus carries an odd parity bit.

In the write direction the block takes bytes from a valid/ready input stream. Each byte, with its parity, goes onto the bus at the falling edge of a strobe. In the read direction the block samples the bus at the rising edge of each strobe and offers the byte on a valid/ready output stream. A parity mismatch on a read sets a sticky error flag. When the memory withdraws its request, the block moves exactly one more byte. It then releases chip select a fixed time later and afterwards stops driving the strobe. If the internal side has no byte to give, or cannot take one, the block holds off the next strobe until it can.

Top module: `bbd_dma_master`

## Requirements
- R1: After reset, cs_oe_o and stb_oe_o are 0, stb_n_o is 1, bus_drive_o, in_ready, out_valid and par_err_o are 0.
- R2: When drq_i is sampled high while idle, cs_oe_o and stb_oe_o go to 1 at that clock edge, and stb_n_o stays 1. The direction is latched from cfg_dir (0 = write to memory, 1 = read from memory).
- R3: The first strobe falls exactly 2 clock cycles after cs_oe_o rises (CS_SETUP = 2).
- R4: The effective period is Tp = max(2, cfg_period). While data is available, successive strobe falls are exactly Tp cycles apart. Each low pulse lasts floor(Tp/2) cycles.
- R5: The final byte is the first strobe fall at a clock edge strictly later than the edge at which drq_i is first sampled low. No strobe falls after the final one.
- R6: If drq_i is first sampled low before the first strobe falls, exactly one byte is transferred.
- R7: cs_oe_o returns to 0 at the first clock edge that is at least REL_CYC = 9 edges after drq_i was first sampled low and that comes after the final strobe has risen.
- R8: stb_n_o is 1 whenever cs_oe_o falls. stb_oe_o stays 1 while cs_oe_o is 1 and drops one cycle after cs_oe_o drops.
- R9: In write direction, bus_drive_o is 1 while chip select is active. bus_d_o takes the accepted input byte at each strobe fall and holds it at least until the next fall. bus_p_o is odd parity (~^ of the byte).
- R10: In read direction, the block captures bus_d_i at each strobe rise and presents it on out_data with out_valid. If bus_p_i differs from ~^bus_d_i, par_err_o is set and stays set until reset.
- R11: With in_valid low (write), or with out_valid high and out_ready low (read), no strobe falls. Chip select stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | 8 | Transfer period in cycles (values below 2 act as 2) |
| cfg_dir | input | 1 | 0 = write to memory, 1 = read from memory |
| drq_i | input | 1 | Transfer request from the memory |
| cs_n_o | output | 1 | Chip select level, low while driven |
| cs_oe_o | output | 1 | Open-drain pull-down enable for chip select |
| stb_n_o | output | 1 | Active-low write/read strobe |
| stb_oe_o | output | 1 | Strobe output enable |
| bus_drive_o | output | 1 | Data bus direction: 1 = block drives bus |
| bus_d_o | output | 8 | Write data to memory |
| bus_p_o | output | 1 | Odd parity of bus_d_o |
| bus_d_i | input | 8 | Read data from memory |
| bus_p_i | input | 1 | Parity of bus_d_i |
| in_valid | input | 1 | Input stream byte valid |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output stream byte valid |
| out_data | output | 8 | Output stream byte |
| out_ready | input | 1 | Consumer accepts the output byte |
| par_err_o | output | 1 | Sticky read parity error |

## Verification
The checker watches every cycle. It checks that the strobe is high and enabled whenever chip select is released, that chip select has been held for two cycles before any strobe falls, and that the gap between falls is never shorter than the period. It also checks that the low width matches the period, that write data and parity hold still while the strobe is low, and that the parity error never clears. Other behaviour depends on where the request drops relative to the strobe train, and only the bench scenarios show it: the exact count of bytes, the release delay, the stall under back-pressure, and the captured read bytes.

// File: rtl/bbd_pkg.sv
package bbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_TAIL
    } bbd_state_e;

    // Odd parity: returned bit makes the total count of ones odd
    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/bbd_pacer.sv
// Strobe period / low-width timer, restarted at each strobe fall
module bbd_pacer #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_period,
    input  logic          fall,
    output logic          gap_ok,
    output logic          rise_due
);
    localparam logic [PW-1:0] PH_MAX = {PW{1'b1}};
    localparam logic [PW-1:0] TP_MIN = PW'(2);

    typedef struct packed {
        logic [PW-1:0] ph;
    } pacer_t;

    pacer_t        q, d;
    logic [PW-1:0] eff_tp;
    logic [PW-1:0] low_w;

    always_comb begin
        eff_tp = (cfg_period < TP_MIN) ? TP_MIN : cfg_period;
        low_w  = eff_tp >> 1;
        d = q;
        if (fall) begin
            d.ph = PW'(1);
        end else if (q.ph != PH_MAX) begin
            d.ph = q.ph + PW'(1);
        end
    end

    assign gap_ok   = (q.ph >= eff_tp);
    assign rise_due = (q.ph == low_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bbd_stop_ctl.sv
// Tracks request withdrawal, the final byte and the release delay
module bbd_stop_ctl #(
    parameter int REL_CYC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic clear,
    input  logic drq,
    input  logic fall,
    input  logic rise,
    output logic final_issued,
    output logic release_ok
);
    localparam int RCW = $clog2(REL_CYC + 1);
    localparam logic [RCW-1:0] RC_END = RCW'(REL_CYC);

    typedef struct packed {
        logic           armed;
        logic [RCW-1:0] rc;
        logic           last_fall;
        logic           last_done;
    } stop_t;

    stop_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (active) begin
            if (!q.armed && !drq) begin
                d.armed = 1'b1;
                d.rc    = RCW'(1);
            end
            if (q.armed && q.rc < RC_END) begin
                d.rc = q.rc + RCW'(1);
            end
            if (fall && q.armed) begin
                d.last_fall = 1'b1;
            end
            if (rise && q.last_fall) begin
                d.last_done = 1'b1;
            end
        end
    end

    assign final_issued = q.last_fall;
    assign release_ok   = q.armed && (q.rc >= RC_END) && q.last_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bbd_datapath.sv
// Write holding register, read capture and parity
module bbd_datapath #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_take,
    input  logic [DW-1:0] in_data,
    input  logic          rd_cap,
    input  logic [DW-1:0] bus_d_i,
    input  logic          bus_p_i,
    input  logic          out_ready,
    output logic [DW-1:0] bus_d_o,
    output logic          bus_p_o,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          par_err
);
    import bbd_pkg::*;

    typedef struct packed {
        logic [DW-1:0] wr_d;
        logic          wr_p;
        logic [DW-1:0] rd_d;
        logic          rd_v;
        logic          err;
    } dp_t;

    dp_t q, d;

    always_comb begin
        d = q;
        if (wr_take) begin
            d.wr_d = in_data;
            d.wr_p = odd_par(in_data);
        end
        if (q.rd_v && out_ready) begin
            d.rd_v = 1'b0;
        end
        if (rd_cap) begin
            d.rd_d = bus_d_i;
            d.rd_v = 1'b1;
            if (bus_p_i != odd_par(bus_d_i)) begin
                d.err = 1'b1;
            end
        end
    end

    assign bus_d_o   = q.wr_d;
    assign bus_p_o   = q.wr_p;
    assign out_valid = q.rd_v;
    assign out_data  = q.rd_d;
    assign par_err   = q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bbd_dma_master.sv
module bbd_dma_master #(
    parameter int PW       = 8,
    parameter int DW       = 8,
    parameter int CS_SETUP = 2,
    parameter int REL_CYC  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_period,
    input  logic          cfg_dir,
    input  logic          drq_i,
    output logic          cs_n_o,
    output logic          cs_oe_o,
    output logic          stb_n_o,
    output logic          stb_oe_o,
    output logic          bus_drive_o,
    output logic [DW-1:0] bus_d_o,
    output logic          bus_p_o,
    input  logic [DW-1:0] bus_d_i,
    input  logic          bus_p_i,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    input  logic          out_ready,
    output logic          par_err_o
);
    import bbd_pkg::*;

    localparam int SUW = $clog2(CS_SETUP + 1);
    localparam logic [SUW-1:0] SU_END = SUW'(CS_SETUP);

    typedef struct packed {
        bbd_state_e     st;
        logic           dir;
        logic           cs_oe;
        logic           stb_oe;
        logic           stb_n;
        logic [SUW-1:0] su;
    } ctl_t;

    ctl_t q, d;

    logic gap_ok, rise_due, final_issued, release_ok;
    logic can_fall, room, fall, rise;

    always_comb begin
        room     = q.dir ? (!out_valid || out_ready) : 1'b1;
        can_fall = ((q.st == ST_SETUP) && (q.su >= SU_END)) ||
                   ((q.st == ST_RUN) && q.stb_n && gap_ok && !final_issued);
        in_ready = can_fall && room && !q.dir;
        fall     = can_fall && room && (q.dir || in_valid);
        rise     = !q.stb_n && rise_due;

        d = q;
        if (fall) d.stb_n = 1'b0;
        if (rise) d.stb_n = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (drq_i) begin
                    d.st     = ST_SETUP;
                    d.cs_oe  = 1'b1;
                    d.stb_oe = 1'b1;
                    d.dir    = cfg_dir;
                    d.su     = SUW'(1);
                end
            end
            ST_SETUP: begin
                if (q.su < SU_END) d.su = q.su + SUW'(1);
                if (fall) d.st = ST_RUN;
            end
            ST_RUN: begin
                if (release_ok) begin
                    d.cs_oe = 1'b0;
                    d.st    = ST_TAIL;
                end
            end
            ST_TAIL: begin
                d.stb_oe = 1'b0;
                d.st     = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.stb_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    bbd_pacer #(.PW(PW)) i_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .fall       (fall),
        .gap_ok     (gap_ok),
        .rise_due   (rise_due)
    );

    bbd_stop_ctl #(.REL_CYC(REL_CYC)) i_stop (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       ((q.st == ST_SETUP) || (q.st == ST_RUN)),
        .clear        (q.st == ST_TAIL),
        .drq          (drq_i),
        .fall         (fall),
        .rise         (rise),
        .final_issued (final_issued),
        .release_ok   (release_ok)
    );

    bbd_datapath #(.DW(DW)) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_take   (fall && !q.dir),
        .in_data   (in_data),
        .rd_cap    (rise && q.dir),
        .bus_d_i   (bus_d_i),
        .bus_p_i   (bus_p_i),
        .out_ready (out_ready),
        .bus_d_o   (bus_d_o),
        .bus_p_o   (bus_p_o),
        .out_valid (out_valid),
        .out_data  (out_data),
        .par_err   (par_err_o)
    );

    assign cs_oe_o     = q.cs_oe;
    assign cs_n_o      = ~q.cs_oe;
    assign stb_n_o     = q.stb_n;
    assign stb_oe_o    = q.stb_oe;
    assign bus_drive_o = q.cs_oe && !q.dir;
endmodule

// File: rtl/bbd_dma_master_chk.sv
module bbd_dma_master_chk #(
    parameter int PW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] cfg_period,
    input logic          cs_oe_o,
    input logic          stb_n_o,
    input logic          stb_oe_o,
    input logic          bus_drive_o,
    input logic [DW-1:0] bus_d_o,
    input logic          bus_p_o,
    input logic          par_err_o
);
    logic [PW-1:0] eff_tp;
    logic [PW-1:0] gap_q;
    logic          prev_q;
    logic          seen_q;

    assign eff_tp = (cfg_period < PW'(2)) ? PW'(2) : cfg_period;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            prev_q <= 1'b1;
            seen_q <= 1'b0;
        end else begin
            prev_q <= stb_n_o;
            if (prev_q && !stb_n_o) gap_q <= PW'(1);
            else if (gap_q != {PW{1'b1}}) gap_q <= gap_q + PW'(1);
            if (!cs_oe_o) seen_q <= 1'b0;
            else if (prev_q && !stb_n_o) seen_q <= 1'b1;
        end
    end

    // R8
    cs_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_oe_o |-> stb_oe_o);
    // R8
    release_stb_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_oe_o) |-> (stb_n_o && stb_oe_o));
    // R3
    cs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_n_o) |-> ($past(cs_oe_o) && $past(cs_oe_o, 2)));
    // R4
    fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q && !stb_n_o && seen_q) |-> (gap_q >= eff_tp));
    // R4
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_q && stb_n_o && cs_oe_o) |-> (gap_q == (eff_tp >> 1)));
    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_o && !stb_n_o && $past(!stb_n_o)) |-> $stable(bus_d_o));
    // R9
    wr_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive_o && !stb_n_o) |-> (bus_p_o == ~^bus_d_o));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |=> par_err_o);
endmodule

bind bbd_dma_master bbd_dma_master_chk #(.PW(PW), .DW(DW)) i_chk (.*);

// File: tb/test_bbd_dma_master.sv
module test_bbd_dma_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_period = 8'd4;
    logic       cfg_dir = 1'b0;
    logic       drq_i = 1'b0;
    logic       cs_n_o, cs_oe_o, stb_n_o, stb_oe_o, bus_drive_o, bus_p_o;
    logic [7:0] bus_d_o, out_data;
    logic [7:0] bus_d_i = '0;
    logic       bus_p_i = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, par_err_o;
    logic       out_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic exp_err = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bbd_dma_master i_bbd_dma_master (.*);

    typedef struct packed {
        logic       dir;
        logic [7:0] tp;
        logic [3:0] n;
        logic       bad;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'd4,  4'd3, 1'b0},
        '{1'b0, 8'd0,  4'd2, 1'b0},
        '{1'b1, 8'd5,  4'd2, 1'b0},
        '{1'b0, 8'd3,  4'd0, 1'b0},
        '{1'b1, 8'd20, 4'd1, 1'b0},
        '{1'b1, 8'd2,  4'd3, 1'b1}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int v, input int k);
        return 8'((8'h5A ^ (v * 29)) + (k * 71));
    endfunction

    task automatic set_rd(input int v, input int k, input logic bad);
        bus_d_i = pat(v, k);
        bus_p_i = (~^pat(v, k)) ^ (bad && k == 0);
    endtask

    task automatic run_vec(input int vi);
        vec_t v;
        int tp, lw, frel, rexp;
        int falls, rises, reads, cs_rise, last_fall, c_drop, guard;
        logic prev_stb, dropped, done;
        v = VEC[vi];
        tp = (v.tp < 2) ? 2 : int'(v.tp);
        lw = tp / 2;
        frel = (v.n == 0) ? 1 : tp - 1;
        rexp = (frel + lw + 1 > 9) ? frel + lw + 1 : 9;
        falls = 0; rises = 0; reads = 0; cs_rise = -1; last_fall = -1;
        c_drop = -1; guard = 0; prev_stb = 1'b1; dropped = 1'b0; done = 1'b0;
        cfg_dir = v.dir; cfg_period = v.tp; in_valid = 1'b1; out_ready = 1'b1;
        in_data = pat(vi, 0);
        set_rd(vi, 0, v.bad);
        @(negedge clk);
        drq_i = 1'b1;
        while (!done && guard < 600) begin
            @(negedge clk);
            guard++;
            if (guard == 1)
                chk(cs_oe_o && stb_oe_o && stb_n_o, "R2 burst start", int'(cs_oe_o), 1);
            if (cs_rise < 0 && cs_oe_o) begin
                cs_rise = cyc;
                if (v.n == 0) begin drq_i = 1'b0; c_drop = cyc; dropped = 1'b1; end
            end
            if (!v.dir && cs_oe_o)
                chk(bus_drive_o, "R9 bus direction", int'(bus_drive_o), 1);
            if (prev_stb && !stb_n_o) begin
                if (falls == 0) chk(cyc - cs_rise == 2, "R3 cs setup", cyc - cs_rise, 2);
                else chk(cyc - last_fall == tp, "R4 fall spacing", cyc - last_fall, tp);
                if (!v.dir) begin
                    chk(bus_d_o == pat(vi, falls), "R9 write data", int'(bus_d_o), int'(pat(vi, falls)));
                    chk(bus_p_o == ~^pat(vi, falls), "R9 write parity", int'(bus_p_o), int'(~^pat(vi, falls)));
                end
                last_fall = cyc;
                falls++;
                in_data = pat(vi, falls);
                if (!dropped && v.n != 0 && falls == int'(v.n)) begin
                    drq_i = 1'b0; c_drop = cyc; dropped = 1'b1;
                end
            end
            if (!prev_stb && stb_n_o && cs_oe_o) begin
                chk(cyc - last_fall == lw, "R4 low width", cyc - last_fall, lw);
                rises++;
                set_rd(vi, rises, v.bad);
            end
            if (out_valid) begin
                chk(out_data == pat(vi, reads), "R10 read data", int'(out_data), int'(pat(vi, reads)));
                reads++;
            end
            if (cs_rise >= 0 && !cs_oe_o) begin
                done = 1'b1;
                chk(cyc - c_drop - 1 == rexp, "R7 release delay", cyc - c_drop - 1, rexp);
                chk(stb_n_o && stb_oe_o, "R8 strobe high at release", int'(stb_n_o && stb_oe_o), 1);
            end
            prev_stb = stb_n_o;
        end
        if (!done) chk(1'b0, "R7 release timeout", guard, 0);
        @(negedge clk);
        chk(!stb_oe_o, "R8 strobe tri-state", int'(stb_oe_o), 0);
        if (v.n == 0) chk(falls == 1, "R6 single byte", falls, 1);
        else chk(falls == int'(v.n) + 1, "R5 one more byte", falls, int'(v.n) + 1);
        if (v.dir) begin
            chk(reads == int'(v.n) + 1, "R10 read count", reads, int'(v.n) + 1);
            exp_err = exp_err | v.bad;
        end
        chk(par_err_o == exp_err, "R10 parity error flag", int'(par_err_o), int'(exp_err));
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle();
        int g = 0;
        while (cs_oe_o && g < 400) begin @(negedge clk); g++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int falls;
        logic prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!cs_oe_o && !stb_oe_o && stb_n_o && !bus_drive_o, "R1 reset bus pins", int'(cs_oe_o), 0);
        chk(!in_ready && !out_valid && !par_err_o, "R1 reset stream", int'(in_ready || out_valid || par_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cs_oe_o && stb_n_o && !stb_oe_o, "R1 after reset", int'(cs_oe_o), 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R11 write stall: no input byte, no strobe
        cfg_dir = 1'b0; cfg_period = 8'd3; in_valid = 1'b0; in_data = 8'hC3;
        @(negedge clk); drq_i = 1'b1;
        repeat (8) @(negedge clk);
        chk(cs_oe_o && stb_n_o, "R11 write stall", int'(stb_n_o), 1);
        in_valid = 1'b1;
        @(negedge clk);
        chk(!stb_n_o && bus_d_o == 8'hC3, "R11 write resumes", int'(bus_d_o), 8'hC3);
        drq_i = 1'b0;
        wait_idle();

        // R11 read stall: output byte not taken, no next strobe
        cfg_dir = 1'b1; cfg_period = 8'd3; out_ready = 1'b0;
        bus_d_i = 8'h11; bus_p_i = ~^8'h11;
        @(negedge clk); drq_i = 1'b1;
        begin
            int g = 0;
            while (!out_valid && g < 100) begin @(negedge clk); g++; end
        end
        falls = 0; prev = stb_n_o;
        repeat (8) begin
            @(negedge clk);
            if (prev && !stb_n_o) falls++;
            prev = stb_n_o;
        end
        chk(falls == 0 && out_valid && cs_oe_o, "R11 read stall", falls, 0);
        chk(out_data == 8'h11, "R10 held read byte", int'(out_data), 8'h11);
        drq_i = 1'b0; out_ready = 1'b1;
        wait_idle();
        chk(par_err_o == exp_err, "R10 sticky error", int'(par_err_o), int'(exp_err));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule